// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a configuration image into a target programmable device over a one-bit serial port. On a start strobe it switches the target's power on and waits a settle time. It then pulses the active-low program request for a fixed time and polls the target's ready line until the target is ready or the poll budget runs out. After that it shifts the image bytes out, most significant bit first, on a data line. Each bit is marked by a pulse on a configuration clock that the block generates itself.

The image arrives as a byte stream with a valid/ready handshake, and the byte count is captured at start. When the last byte has gone out, or when the stream signals an error, the block keeps pulsing the configuration clock until the target reports completion or an extra-clock budget is spent. The outcome is held on a success flag or an error flag until the next start. The delays and budgets are parameters counted in system clock cycles, so a bench can shorten them.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset: tgtPower=0, progN=1, cfgClk=0, cfgData=0, busy=0, okFlag=0, errFlag=0, inReady=0.
- R2: A start while idle raises tgtPower and busy on the next edge. progN falls exactly SETTLE_CYC cycles after tgtPower rises. tgtPower then stays high until reset.
- R3: progN stays low for exactly PULSE_CYC cycles, then returns high, and it pulses exactly once per load.
- R4: After progN is released, tgtReady is polled once per cycle for at most INIT_LIMIT polls. A poll that sees it high starts the data phase. If all INIT_LIMIT polls see it low, errFlag is set after exactly INIT_LIMIT cycles of polling and cfgClk never rises.
- R5: Bytes are taken when inValid and inReady are both high; inReady is high only while a byte is awaited. Each byte goes out MSB first, with cfgData changing only while cfgClk is low. There is one cfgClk rise per bit, and exactly byteCount bytes are sent.
- R6: inError seen while inReady is high ends the data phase at once. That byte and all later bytes are not sent, and the completion phase follows.
- R7: In the completion phase, cfgClk keeps pulsing until tgtComplete is high. If tgtComplete is seen high, okFlag is set, after at most DONE_LIMIT extra rises. If DONE_LIMIT extra rises pass without it, errFlag is set instead.
- R8: okFlag and errFlag are never both high. They hold with busy low until the next start, which clears them. A start while busy has no effect.
- R9: A byteCount of 0 skips the data phase and goes straight to the completion phase.
- R10: cfgClk is low whenever busy is low, including after both success and failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| byteCount | input | CNT_W | Number of image bytes, captured at start |
| inData | input | 8 | Image byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Loader awaits a byte |
| inError | input | 1 | Stream failed; end the data phase |
| tgtReady | input | 1 | Target ready for data (active high) |
| tgtComplete | input | 1 | Target configuration complete (active high) |
| tgtPower | output | 1 | Target power enable |
| progN | output | 1 | Active-low program request |
| cfgClk | output | 1 | Generated configuration clock |
| cfgData | output | 1 | Serial configuration data |
| busy | output | 1 | Load in progress |
| okFlag | output | 1 | Last load succeeded |
| errFlag | output | 1 | Last load failed |

## Verification
tgtPower and busy change one edge after start is sampled, progN falls SETTLE_CYC edges after that, and each bit takes two edges: a low phase that sets cfgData and a high phase that raises cfgClk. The bench acts as the target. At every falling system-clock edge it counts cycles and cfgClk rises, captures cfgData at each rise, and answers on tgtReady and tgtComplete. Timing checks are therefore made on counted cycle numbers, not on wall time. Final flags and counts are checked only after busy has been seen low, and the corner cases put tgtReady and tgtComplete exactly on, and one past, their budgets.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_PULSE, ST_POLL, ST_FETCH, ST_SHIFT, ST_FLUSH
  } ldState_t;

  typedef struct packed {
    logic loadSettle;
    logic loadPulse;
    logic timerDec;
    logic loadCount;
    logic clrLim;
    logic incLim;
    logic takeByte;
    logic putBit;
    logic shiftBit;
    logic decCount;
  } strobes_t;
endpackage

// File: rtl/cfgl_dp.sv
module cfgl_dp import cfgl_pkg::*; #(
  parameter int SETTLE_CYC = 5000000,
  parameter int PULSE_CYC  = 5000000,
  parameter int INIT_LIMIT = 100000,
  parameter int DONE_LIMIT = 100000,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [BYTE_W-1:0] inData,
  output logic              timerZero,
  output logic              pollLast,
  output logic              extraFull,
  output logic              bitLast,
  output logic              countZero,
  output logic              countOne,
  output logic              cfgData
);
  localparam int MAX_T = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam int MAX_L = (INIT_LIMIT > DONE_LIMIT) ? INIT_LIMIT : DONE_LIMIT;
  localparam int LW    = $clog2(MAX_L + 1);

  logic [TW-1:0]     timer;
  logic [LW-1:0]     limCnt;
  logic [CNT_W-1:0]  remain;
  logic [BYTE_W-1:0] shReg;
  logic [BIT_W-1:0]  bitCnt;
  logic              dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer  <= '0;
      limCnt <= '0;
      remain <= '0;
      shReg  <= '0;
      bitCnt <= '0;
      dataQ  <= 1'b0;
    end else begin
      if (stb.loadSettle)     timer <= TW'(SETTLE_CYC - 1);
      else if (stb.loadPulse) timer <= TW'(PULSE_CYC - 1);
      else if (stb.timerDec)  timer <= timer - 1'b1;

      if (stb.clrLim)      limCnt <= '0;
      else if (stb.incLim) limCnt <= limCnt + 1'b1;

      if (stb.loadCount) begin
        remain <= byteCount;
        dataQ  <= 1'b0;
      end else if (stb.decCount) begin
        remain <= remain - 1'b1;
      end

      if (stb.takeByte) begin
        shReg  <= inData;
        bitCnt <= '0;
      end else if (stb.shiftBit) begin
        shReg  <= {shReg[BYTE_W-2:0], 1'b0};
        bitCnt <= bitCnt + 1'b1;
      end

      if (stb.putBit) dataQ <= shReg[BYTE_W-1];
    end
  end

  assign timerZero = (timer == '0);
  assign pollLast  = (limCnt == LW'(INIT_LIMIT - 1));
  assign extraFull = (limCnt == LW'(DONE_LIMIT));
  assign bitLast   = (bitCnt == BIT_W'(BYTE_W - 1));
  assign countZero = (remain == '0);
  assign countOne  = (remain == CNT_W'(1));
  assign cfgData   = dataQ;
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl import cfgl_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     inValid,
  input  logic     inError,
  input  logic     tgtReady,
  input  logic     tgtComplete,
  input  logic     timerZero,
  input  logic     pollLast,
  input  logic     extraFull,
  input  logic     bitLast,
  input  logic     countZero,
  input  logic     countOne,
  output strobes_t stb,
  output logic     inReady,
  output logic     tgtPower,
  output logic     progN,
  output logic     cfgClk,
  output logic     busy,
  output logic     okFlag,
  output logic     errFlag
);
  ldState_t state, nxt;
  logic     phase;

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (start) begin
        stb.loadSettle = 1'b1;
        stb.loadCount  = 1'b1;
        nxt = ST_SETTLE;
      end
      ST_SETTLE: if (timerZero) begin
        stb.loadPulse = 1'b1;
        nxt = ST_PULSE;
      end else stb.timerDec = 1'b1;
      ST_PULSE: if (timerZero) begin
        stb.clrLim = 1'b1;
        nxt = ST_POLL;
      end else stb.timerDec = 1'b1;
      ST_POLL: if (tgtReady) begin
        stb.clrLim = 1'b1;
        nxt = countZero ? ST_FLUSH : ST_FETCH;
      end else if (pollLast) nxt = ST_IDLE;
      else stb.incLim = 1'b1;
      ST_FETCH: if (inError) nxt = ST_FLUSH;
      else if (inValid) begin
        stb.takeByte = 1'b1;
        nxt = ST_SHIFT;
      end
      ST_SHIFT: if (!phase) stb.putBit = 1'b1;
      else begin
        stb.shiftBit = 1'b1;
        if (bitLast) begin
          stb.decCount = 1'b1;
          nxt = countOne ? ST_FLUSH : ST_FETCH;
        end
      end
      ST_FLUSH: if (tgtComplete) nxt = ST_IDLE;
      else if (!cfgClk) begin
        if (extraFull) nxt = ST_IDLE;
        else stb.incLim = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tgtPower <= 1'b0;
      progN    <= 1'b1;
      cfgClk   <= 1'b0;
      busy     <= 1'b0;
      okFlag   <= 1'b0;
      errFlag  <= 1'b0;
      phase    <= 1'b0;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE: if (start) begin
          tgtPower <= 1'b1;
          busy     <= 1'b1;
          okFlag   <= 1'b0;
          errFlag  <= 1'b0;
          progN    <= 1'b1;
          cfgClk   <= 1'b0;
          phase    <= 1'b0;
        end
        ST_SETTLE: if (timerZero) progN <= 1'b0;
        ST_PULSE:  if (timerZero) progN <= 1'b1;
        ST_POLL: if (!tgtReady && pollLast) begin
          errFlag <= 1'b1;
          busy    <= 1'b0;
        end
        ST_FETCH: cfgClk <= 1'b0;
        ST_SHIFT: begin
          cfgClk <= phase;
          phase  <= ~phase;
        end
        ST_FLUSH: if (tgtComplete) begin
          okFlag <= 1'b1;
          busy   <= 1'b0;
          cfgClk <= 1'b0;
        end else if (cfgClk) cfgClk <= 1'b0;
        else if (extraFull) begin
          errFlag <= 1'b1;
          busy    <= 1'b0;
        end else cfgClk <= 1'b1;
        default: ;
      endcase
    end
  end

  assign inReady = (state == ST_FETCH);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader import cfgl_pkg::*; #(
  parameter int SETTLE_CYC = 5000000,
  parameter int PULSE_CYC  = 5000000,
  parameter int INIT_LIMIT = 100000,
  parameter int DONE_LIMIT = 100000,
  parameter int CNT_W      = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inError,
  input  logic             tgtReady,
  input  logic             tgtComplete,
  output logic             tgtPower,
  output logic             progN,
  output logic             cfgClk,
  output logic             cfgData,
  output logic             busy,
  output logic             okFlag,
  output logic             errFlag
);
  strobes_t stb;
  logic timerZero, pollLast, extraFull, bitLast, countZero, countOne;

  cfgl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inError(inError),
    .tgtReady(tgtReady), .tgtComplete(tgtComplete), .timerZero(timerZero),
    .pollLast(pollLast), .extraFull(extraFull), .bitLast(bitLast),
    .countZero(countZero), .countOne(countOne), .stb(stb), .inReady(inReady),
    .tgtPower(tgtPower), .progN(progN), .cfgClk(cfgClk), .busy(busy),
    .okFlag(okFlag), .errFlag(errFlag)
  );

  cfgl_dp #(
    .SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC), .INIT_LIMIT(INIT_LIMIT),
    .DONE_LIMIT(DONE_LIMIT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .byteCount(byteCount), .inData(inData),
    .timerZero(timerZero), .pollLast(pollLast), .extraFull(extraFull),
    .bitLast(bitLast), .countZero(countZero), .countOne(countOne),
    .cfgData(cfgData)
  );
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic progN,
  input logic cfgClk,
  input logic cfgData,
  input logic okFlag,
  input logic errFlag,
  input logic tgtPower
);
  // R8: outcome flags are exclusive
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(okFlag && errFlag));

  // R8: flags hold while idle
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> ($stable(okFlag) && $stable(errFlag)));

  // R5: data never changes on the edge that raises the clock
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  // R3: program request only during a load
  a_r3_prog_in_load: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> busy);

  // R10: clock parked low while idle
  a_r10_clk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cfgClk);

  // R2: power never drops once raised
  a_r2_power_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(tgtPower));
endmodule

bind cfg_serial_loader cfgl_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .progN(progN), .cfgClk(cfgClk),
  .cfgData(cfgData), .okFlag(okFlag), .errFlag(errFlag), .tgtPower(tgtPower)
);

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  localparam int SET = 6, PUL = 5, IL = 12, DL = 10, CW = 8;

  logic clk = 0, rstN = 0, start = 0;
  logic [CW-1:0] byteCount = '0;
  logic [7:0] inData = '0;
  logic inValid = 0, inError = 0, tgtReady = 1, tgtComplete = 0;
  logic inReady, tgtPower, progN, cfgClk, cfgData, busy, okFlag, errFlag;

  cfg_serial_loader #(.SETTLE_CYC(SET), .PULSE_CYC(PUL), .INIT_LIMIT(IL),
    .DONE_LIMIT(DL), .CNT_W(CW)) dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] mem [16];
  logic [7:0] capt [16];
  int nBytes = 0, errAt = 99, initDelay = 0, doneAt = 0, accExp = 0;
  int idx = 0, riseCnt = 0, sinceProg = 0, settleCnt = 0, pulseCnt = 0;
  int waitCnt = 0, progFalls = 0;
  bit pendFire = 0, seenPulse = 0, prevClk = 0, prevProg = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
  function automatic bit expOk(input int dly, input int extra);
    return (dly <= IL) && (extra <= DL);
  endfunction

  // target model and byte feeder, all away from the active edge
  always @(negedge clk) begin
    if (cfgClk && !prevClk) begin
      if (riseCnt < 8 * accExp)
        capt[riseCnt / 8] = {capt[riseCnt / 8][6:0], cfgData};
      riseCnt++;
    end
    if (prevProg && !progN) progFalls++;
    if (busy && tgtPower && progN && !seenPulse) settleCnt++;
    if (!progN) begin
      pulseCnt++;
      seenPulse = 1;
      sinceProg = 0;
      tgtReady = 0;
      tgtComplete = 0;
      riseCnt = 0;
    end else if (seenPulse && busy) begin
      if (riseCnt == 0) waitCnt++;
      sinceProg++;
      tgtReady = (sinceProg >= initDelay);
      if (riseCnt >= doneAt) tgtComplete = 1;
    end
    prevClk = cfgClk;
    prevProg = progN;
    if (pendFire) idx++;
    inError = (idx == errAt) && (idx < nBytes);
    inValid = (idx < nBytes) && !inError && ($urandom % 4 != 0);
    inData = mem[idx % 16];
    pendFire = inValid && inReady && !inError;
  end

  task automatic runLoad(input int n, input int dly, input int extra,
                         input int eAt, input bit poke, input string tag);
    bit initOk;
    int expRise;
    initOk = (dly <= IL);
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'($urandom);
      capt[i] = '0;
    end
    nBytes = n; errAt = eAt; initDelay = dly; idx = 0; pendFire = 0;
    accExp = initOk ? minI(n, eAt) : 0;
    doneAt = 8 * accExp + extra;
    riseCnt = 0; settleCnt = 0; pulseCnt = 0; waitCnt = 0; progFalls = 0;
    seenPulse = 0; sinceProg = 0;
    byteCount = CW'(n);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !okFlag && !errFlag && tgtPower, "R8", {tag, " flags cleared, busy"},
        {busy, okFlag, errFlag}, 3'b100);
    for (int i = 0; i < 3000 && busy; i++) begin
      @(negedge clk);
      start = (poke && i == 40);
    end
    start = 0;
    @(negedge clk);
    chk(!busy, "R8", {tag, " load finished"}, busy, 0);
    chk(settleCnt == SET, "R2", {tag, " settle cycles"}, settleCnt, SET);
    chk(pulseCnt == PUL, "R3", {tag, " program pulse cycles"}, pulseCnt, PUL);
    chk(progFalls == 1, "R3", {tag, " single program pulse"}, progFalls, 1);
    chk(okFlag == expOk(dly, extra), "R7", {tag, " okFlag"}, okFlag, expOk(dly, extra));
    chk(errFlag == !expOk(dly, extra), "R7", {tag, " errFlag"}, errFlag, !expOk(dly, extra));
    expRise = initOk ? 8 * accExp + minI(extra, DL) : 0;
    chk(riseCnt == expRise, "R5", {tag, " clock rises"}, riseCnt, expRise);
    chk(!cfgClk && tgtPower && progN, "R10", {tag, " idle pins"},
        {cfgClk, tgtPower, progN}, 3'b011);
    if (!initOk)
      chk(waitCnt == IL, "R4", {tag, " poll cycles before timeout"}, waitCnt, IL);
    for (int b = 0; b < accExp; b++)
      chk(capt[b] == mem[b], (eAt < n) ? "R6" : "R5", {tag, " byte MSB first"},
          capt[b], mem[b]);
    repeat (3) @(negedge clk);
    chk(okFlag == expOk(dly, extra) && !busy, "R8", {tag, " flags held"},
        okFlag, expOk(dly, extra));
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0F1));
    repeat (3) @(negedge clk);
    chk({tgtPower, progN, cfgClk, cfgData, busy, okFlag, errFlag, inReady} == 8'b01000000,
        "R1", "reset state", {tgtPower, progN, cfgClk, cfgData, busy, okFlag, errFlag, inReady},
        8'b01000000);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(!tgtPower && !busy, "R1", "idle after reset", {tgtPower, busy}, 0);
    runLoad(3, 3, 4, 99, 1, "basic+restart");       // R8 start while busy
    runLoad(2, 1000, 0, 99, 0, "init timeout");     // R4
    runLoad(2, IL, 0, 99, 0, "init last poll");     // R4
    runLoad(1, 0, DL, 99, 0, "done at limit");      // R7
    runLoad(1, 0, DL + 1, 99, 0, "done past limit"); // R7
    runLoad(5, 2, 3, 2, 0, "stream error");         // R6
    runLoad(0, 1, 5, 99, 0, "zero bytes");          // R9
    runLoad(0, 1, 0, 99, 0, "zero bytes instant");  // R9
    for (int k = 0; k < 8; k++) begin
      int n, e;
      n = 1 + int'($urandom % 6);
      e = ($urandom % 3 == 0) ? int'($urandom % n) : 99;
      runLoad(n, int'($urandom % (IL + 1)), int'($urandom % (DL + 3)), e, 0, "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule